// File: doc/BRIEF.md
# Double-Buffered Clock Register Bank

This block is the host-facing window onto a running calendar. Eight byte registers occupy the eight highest addresses of a byte-wide bus. Each register keeps a user copy of one calendar field. While no hold is active, that copy follows the live counters. The counters themselves live outside the block. The block reads them through a packed input and loads them through a one-cycle load strobe.

The lowest of the eight addresses is a control byte that also carries the century field. Its bit 6 freezes the user copy so the host can read a consistent snapshot. Its bit 7 freezes the user copy and opens the time fields to host writes. Clearing bit 7 sends the user values to the counters. The day register also holds a read-only battery-good flag and a frequency-test enable bit. Every bit with no function is plain storage.

Top module: `rtc_shadow_regs`

## Requirements
- R1: The bank responds only to the top eight addresses, where all address bits above bit 2 are one. Offsets 0 to 7 are, in order: control/century, seconds, minutes, hour, day, date, month, year. Any other address reads zero and `reg_hit` is low there. A write to any other address changes nothing.
- R2: While the hold bit (control bit 6) and the set bit (control bit 7) are both zero, each time field takes the live counter value one clock after it is presented. The field widths are: century bits 5:0, seconds 6:0, minutes 6:0, hour 5:0, day 2:0, date 5:0, month 4:0, year 7:0.
- R3: While the hold bit is one and the set bit is zero, the time fields keep their values. Host writes to time fields are dropped.
- R4: While the set bit is one, the time fields ignore the live counters and take host writes. A control-byte write loads the century field only when its data bit 7 is one.
- R5: A control write with bit 7 zero, made while the set bit is one, raises `load_en` in the next cycle. At that time `load_time` carries the user fields, with all non-field bits zero.
- R6: Refresh resumes on the first clock edge after the control write that clears the hold bit. That is well inside the required refresh window.
- R7: Day bit 7 reads the `batt_good` input and ignores writes.
- R8: Day bit 6 is host-writable storage and drives `ftest_en`.
- R9: The remaining non-field bits are host-writable at any time and are never altered by a refresh. These are seconds bit 7, minutes bit 7, hour bits 7:6, day bits 5:3, date bits 7:6 and month bits 7:5.
- R10: All eight fields refresh on the same clock edge, so no read can mix old and new values.
- R11: With both hold and set bits at one, the set-bit behaviour applies: time fields accept host writes.
- R12: `load_en` is a single-cycle pulse.
- R13: During reset all stored bits are zero and `load_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| reg_hit | output | 1 | Address falls in the eight-register window |
| live_time | input | 64 | Live counter fields, byte i = register offset i |
| batt_good | input | 1 | Battery status |
| load_time | output | 64 | Fields to load into the counters, same packing |
| load_en | output | 1 | Counter load strobe |
| ftest_en | output | 1 | Frequency-test enable |

## Verification
Read data is combinational, so a read is due in the same cycle its address and strobe are driven. The monitor compares it at the following falling edge.

A write takes effect at the next rising edge. A refresh from the live counters lands one edge after that, so the bench leaves one idle cycle before reading refreshed values.

`load_en` rises on the edge that completes the clearing control write. The bench checks it at the falling edge just after that write and again one cycle later, when it must have dropped.

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reg_hit,
  input  logic [63:0]       live_time,
  input  logic              batt_good,
  output logic [63:0]       load_time,
  output logic              load_en,
  output logic              ftest_en
);
  localparam int NREG = 8;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [63:0] FMASK = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F, 8'h3F};
  localparam logic [63:0] SMASK = {8'h00, 8'hE0, 8'hC0, 8'h78, 8'hC0, 8'h80, 8'h80, 8'h00};

  logic [7:0] ureg [NREG];
  logic [7:0] nxt  [NREG];
  logic       hold_b, set_b, ld;
  logic [IDX_W-1:0] idx;
  logic       wr, ctl_wr, refresh;

  assign idx     = bus_addr[IDX_W-1:0];
  assign reg_hit = &bus_addr[ADDR_W-1:IDX_W];
  assign wr      = bus_wr && reg_hit;
  assign ctl_wr  = wr && (idx == '0);
  assign refresh = !hold_b && !set_b && !ctl_wr && !ld;
  assign load_en = ld;
  assign ftest_en = ureg[4][6];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = ureg[i];
      if (refresh)
        nxt[i] = (nxt[i] & ~FMASK[8*i +: 8]) | (live_time[8*i +: 8] & FMASK[8*i +: 8]);
      if (wr && idx == IDX_W'(i)) begin
        nxt[i] = (nxt[i] & ~SMASK[8*i +: 8]) | (bus_wdata & SMASK[8*i +: 8]);
        if ((i == 0) ? bus_wdata[7] : set_b)
          nxt[i] = (nxt[i] & ~FMASK[8*i +: 8]) | (bus_wdata & FMASK[8*i +: 8]);
      end
      load_time[8*i +: 8] = ureg[i] & FMASK[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ureg[i] <= '0;
      hold_b <= 1'b0;
      set_b  <= 1'b0;
      ld     <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) ureg[i] <= nxt[i];
      ld <= ctl_wr && set_b && !bus_wdata[7];
      if (ctl_wr) begin
        hold_b <= bus_wdata[6];
        set_b  <= bus_wdata[7];
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0:    bus_rdata = {set_b, hold_b, ureg[0][5:0]};
      3'd4:    bus_rdata = {batt_good, ureg[4][6:0]};
      default: bus_rdata = ureg[idx];
    endcase
    if (!(bus_rd && reg_hit)) bus_rdata = '0;
  end

  p_refresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_b && !set_b && !ld && !ctl_wr) |=>
      (ureg[1][6:0] == $past(live_time[14:8]) && ureg[7] == $past(live_time[63:56])));

  p_coherent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_b && !set_b && !ld && !ctl_wr) |=>
      (ureg[0][5:0] == $past(live_time[5:0]) && ureg[4][2:0] == $past(live_time[34:32])));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_b && !set_b && !ctl_wr) |=> ($stable(ureg[1][6:0]) && $stable(ureg[2][6:0])));

  p_sethold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_b && !(wr && idx == 3'd1)) |=> $stable(ureg[1][6:0]));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && set_b && !bus_wdata[7]) |=> load_en);

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en);

  p_batt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reg_hit && idx == 3'd4) |-> (bus_rdata[7] == batt_good));

  p_ftest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 3'd4) |=> (ftest_en == $past(bus_wdata[6])));

  p_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && idx == 3'd1) |=> $stable(ureg[1][7]));
endmodule

// File: tb/sim_rtc_shadow_regs.sv
module sim_rtc_shadow_regs;
  logic clk = 0, rst_n = 0;
  logic [16:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic reg_hit, load_en, ftest_en;
  logic [63:0] live_time = '0, load_time;
  logic batt_good = 1;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  rtc_shadow_regs u0 (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .reg_hit, .live_time, .batt_good, .load_time, .load_en, .ftest_en);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (bus_rd && expq.size() > 0)
    chk(bus_rdata, expq.pop_front(), tagq.pop_front());

  task automatic rd(input logic [16:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1;
    expq.push_back(exp); tagq.push_back(tag);
    @(negedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wrb(input logic [16:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  localparam logic [16:0] B = 17'h1FFF8;

  initial begin
    live_time = {8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h45, 8'h20};
    rd(B + 1, 8'h00, "R13 sec in reset");
    rd(B + 0, 8'h00, "R13 ctrl in reset");
    @(negedge clk); chk(load_en, 0, "R13 load_en");
    rst_n = 1;
    idle(2);
    // R1 R2 ordering and refresh
    rd(B + 0, 8'h20, "R1 century");
    rd(B + 1, 8'h45, "R1 seconds");
    rd(B + 2, 8'h59, "R1 minutes");
    rd(B + 3, 8'h23, "R1 hour");
    rd(B + 4, 8'h85, "R1 day");
    rd(B + 5, 8'h31, "R1 date");
    rd(B + 6, 8'h12, "R1 month");
    rd(B + 7, 8'h99, "R1 year");
    wrb(17'h00000, 8'hFF);
    rd(17'h1FFF7, 8'h00, "R1 outside window");
    chk(reg_hit, 0, "R1 reg_hit outside");
    rd(B + 0, 8'h20, "R1 outside write ignored");
    live_time[15:8] = 8'h46;
    idle(2);
    rd(B + 1, 8'h46, "R2 refresh");
    // R3 hold
    wrb(B + 0, 8'h40);
    live_time[23:8] = {8'h10, 8'h50};
    idle(2);
    rd(B + 1, 8'h46, "R3 sec frozen");
    rd(B + 2, 8'h59, "R3 min frozen");
    rd(B + 0, 8'h60, "R3 ctrl");
    wrb(B + 1, 8'h33);
    rd(B + 1, 8'h46, "R3 field write dropped");
    // R6 release
    wrb(B + 0, 8'h00);
    idle(1);
    rd(B + 1, 8'h50, "R6 sec refreshed");
    rd(B + 2, 8'h10, "R6 min refreshed R10");
    // R9 spare bits
    wrb(B + 1, 8'hC6);
    rd(B + 1, 8'hD0, "R9 spare written, field kept");
    live_time[15:8] = 8'h12;
    idle(2);
    rd(B + 1, 8'h92, "R9 spare survives refresh");
    // R7 R8
    wrb(B + 4, 8'hFF);
    rd(B + 4, 8'hFD, "R8 day spare and ftest");
    chk(ftest_en, 1, "R8 ftest_en set");
    batt_good = 0;
    rd(B + 4, 8'h7D, "R7 battery low");
    wrb(B + 4, 8'h00);
    rd(B + 4, 8'h05, "R7 battery bit not writable");
    chk(ftest_en, 0, "R8 ftest_en cleared");
    batt_good = 1;
    // R4 set clock, R5 commit
    wrb(B + 0, 8'h99);
    live_time[15:8] = 8'h13;
    wrb(B + 1, 8'h07); wrb(B + 2, 8'h08); wrb(B + 3, 8'h09); wrb(B + 4, 8'h03);
    wrb(B + 5, 8'h04); wrb(B + 6, 8'h05); wrb(B + 7, 8'h06);
    rd(B + 1, 8'h07, "R4 sec from host");
    rd(B + 2, 8'h08, "R4 min from host");
    rd(B + 0, 8'h99, "R4 century loaded");
    chk(load_en, 0, "R5 no load while set");
    wrb(B + 0, 8'h19);
    @(negedge clk);
    chk(load_en, 1, "R5 load_en");
    chk(load_time, {8'h06, 8'h05, 8'h04, 8'h03, 8'h09, 8'h08, 8'h07, 8'h19}, "R5 load_time");
    live_time = {8'h06, 8'h05, 8'h04, 8'h03, 8'h09, 8'h08, 8'h08, 8'h19};
    @(negedge clk);
    chk(load_en, 0, "R12 pulse ends");
    idle(2);
    rd(B + 1, 8'h08, "R5 refresh after commit");
    // R11 precedence
    wrb(B + 0, 8'hD9);
    wrb(B + 7, 8'h42);
    rd(B + 7, 8'h42, "R11 year written with both bits");
    rd(B + 0, 8'hD9, "R11 ctrl");
    wrb(B + 0, 8'h19);
    @(negedge clk);
    chk(load_en, 1, "R11 commit pulse");
    chk(load_time[63:56], 8'h42, "R11 year loaded");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule